// File: doc/BRIEF.md
# FIR Configuration and Coefficient Bus Slave

This block sits between an AXI-Lite host and a streaming FIR engine. Through it the host sets the number of samples and the number of taps, loads the coefficients into a single-port tap RAM outside the block, and starts a run. The block then watches the engine's completion pulse and reports idle, done and start in one status word. The done flag stays set until the host reads a status word that shows both idle and done.

The tap RAM has only one port. The bus uses it only while the engine is idle. At all other times the port carries the engine's own enable and address. While the engine runs, coefficient and length writes are accepted on the bus but dropped, and reads of the coefficient window return all ones.

Read data is registered. After the read-address handshake the block takes one cycle to fetch the word and then holds `rvalid` and `rdata` until the host accepts them.

Top module: `fir_cfg_slave`

## Requirements
- R1: After reset, `eng_idle`=1, `eng_start`=0, the status word reads 3'b100 (bit 2 idle, bit 1 done, bit 0 start), both length outputs are 0, and `rvalid`=0.
- R2: `awready` and `wready` rise together, in a cycle where both `awvalid` and `wvalid` are high. If only one of the two is high, neither ready is asserted, whichever of them arrives first.
- R3: The read address is captured at the address handshake, so later changes to `araddr` do not affect the read. `rvalid` is 0 in the cycle after the handshake and 1 in the cycle after that. While `rready` is low, `rvalid` stays high and `rdata` does not change.
- R4: Any address with bit 7 set maps to the tap RAM. The RAM sees the address with every bit above bit 6 cleared. A coefficient write drives `ram_en`=1 and `ram_we`=4'b1111 in the cycle of the write handshake. Coefficient reads return what was stored.
- R5: While idle, a write to 0x10 sets the data length and a write to 0x14 sets the tap length. Both values appear on the configuration outputs and can be read back.
- R6: While busy (idle=0), writes to the coefficient window and to the length registers are acknowledged and have no effect. A coefficient-window read while busy returns 0xFFFFFFFF.
- R7: A write to 0x00 while idle raises `eng_start` for exactly one cycle, starting in the cycle after the write handshake. Idle falls in the cycle after that. A write to 0x00 while busy does nothing.
- R8: A high `eng_done` while busy sets both idle and done at the next clock edge.
- R9: When a status read that returns idle=1 and done=1 completes, done is cleared.
- R10: Whenever the bus is not accessing the tap RAM, and always while busy, `ram_en` and `ram_addr` follow `eng_ram_en` and `eng_ram_addr`, and `ram_we` is 0.
- R11: Writes to an unmapped address (for example 0x40) are acknowledged and do not touch the RAM. Reads of an unmapped address return 0.
- R12: If a write and a read address arrive in the same cycle, the write is accepted and `arready` stays low. The read is accepted in a following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| awaddr | input | ADDR_W | Write byte address |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| wdata | input | DATA_W | Write data |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| araddr | input | ADDR_W | Read byte address |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| rdata | output | DATA_W | Read data |
| eng_done | input | 1 | Pulse from the engine: the last output has been sent |
| eng_start | output | 1 | One-cycle start to the engine |
| eng_idle | output | 1 | Idle state to the engine |
| cfg_data_len | output | DATA_W | Data length setting |
| cfg_tap_len | output | DATA_W | Tap length setting |
| eng_ram_en | input | 1 | Engine's tap RAM enable |
| eng_ram_addr | input | ADDR_W | Engine's tap RAM byte address |
| ram_en | output | 1 | Tap RAM enable |
| ram_we | output | DATA_W/8 | Tap RAM byte write enables |
| ram_addr | output | ADDR_W | Tap RAM byte address |
| ram_wdata | output | DATA_W | Tap RAM write data |
| ram_rdata | input | DATA_W | Tap RAM read data, one cycle after enable |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a write handshake and a read-address handshake. The bench raises `awvalid`, `wvalid` and `arvalid` on the same edge. It then expects the write to be accepted, `arready` to stay low, and the read to be accepted one cycle later with the correct coefficient. The second pair is the engine's use of the tap RAM and a bus coefficient write during a run. With the engine holding its own enable and address, the bench samples the RAM port in the write-handshake cycle. It expects the engine's address and no write enable, and a later readback shows the stored coefficient unchanged.

// File: rtl/fir_cfg_slave.sv
module fir_cfg_slave #(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter int WIN_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              awvalid,
  output logic              awready,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              wvalid,
  output logic              wready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              arvalid,
  output logic              arready,
  input  logic [ADDR_W-1:0] araddr,
  output logic              rvalid,
  input  logic              rready,
  output logic [DATA_W-1:0] rdata,
  input  logic              eng_done,
  output logic              eng_start,
  output logic              eng_idle,
  output logic [DATA_W-1:0] cfg_data_len,
  output logic [DATA_W-1:0] cfg_tap_len,
  input  logic              eng_ram_en,
  input  logic [ADDR_W-1:0] eng_ram_addr,
  output logic              ram_en,
  output logic [DATA_W/8-1:0] ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata,
  input  logic [DATA_W-1:0] ram_rdata
);
  localparam int BE_W = DATA_W / 8;
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_DLEN = ADDR_W'(16'h10);
  localparam logic [ADDR_W-1:0] A_TLEN = ADDR_W'(16'h14);
  localparam logic [ADDR_W-1:0] WIN_MASK = {{(ADDR_W-WIN_BIT){1'b0}}, {WIN_BIT{1'b1}}};

  logic              idle_q, done_q, start_q;
  logic              rd_pend, rd_live_q, rvalid_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rdata_q, dlen_q, tlen_q, rd_word, status;
  logic              wr_fire, ar_fire, bus_wr_ram, bus_rd_ram, done_clear;

  assign wr_fire    = awvalid & wvalid;
  assign ar_fire    = arvalid & ~wr_fire & ~rd_pend & ~rvalid_q;
  assign awready    = wr_fire;
  assign wready     = wr_fire;
  assign arready    = ar_fire;
  assign bus_wr_ram = wr_fire & awaddr[WIN_BIT] & idle_q;
  assign bus_rd_ram = ar_fire & araddr[WIN_BIT] & idle_q;

  assign ram_en    = (bus_wr_ram | bus_rd_ram) ? 1'b1 : eng_ram_en;
  assign ram_we    = {BE_W{bus_wr_ram}};
  assign ram_addr  = bus_wr_ram ? (awaddr & WIN_MASK) :
                     bus_rd_ram ? (araddr & WIN_MASK) : eng_ram_addr;
  assign ram_wdata = wdata;

  assign status = {{(DATA_W-3){1'b0}}, idle_q, done_q, start_q};

  always_comb begin
    if (rd_addr_q[WIN_BIT])      rd_word = rd_live_q ? ram_rdata : '1;
    else if (rd_addr_q == A_CTRL) rd_word = status;
    else if (rd_addr_q == A_DLEN) rd_word = dlen_q;
    else if (rd_addr_q == A_TLEN) rd_word = tlen_q;
    else                          rd_word = '0;
  end

  assign done_clear = rvalid_q & rready & (rd_addr_q == A_CTRL) & rdata_q[2] & rdata_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_addr_q <= '0;
      rd_live_q <= 1'b0;
      rd_pend   <= 1'b0;
      rvalid_q  <= 1'b0;
      rdata_q   <= '0;
    end else begin
      rd_pend <= ar_fire;
      if (ar_fire) begin
        rd_addr_q <= araddr;
        rd_live_q <= idle_q;
      end
      if (rd_pend) begin
        rvalid_q <= 1'b1;
        rdata_q  <= rd_word;
      end else if (rready) begin
        rvalid_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q  <= 1'b1;
      done_q  <= 1'b0;
      start_q <= 1'b0;
      dlen_q  <= '0;
      tlen_q  <= '0;
    end else begin
      start_q <= wr_fire & (awaddr == A_CTRL) & idle_q & ~start_q;
      if (start_q)       idle_q <= 1'b0;
      else if (eng_done) idle_q <= 1'b1;
      if (eng_done & ~idle_q) done_q <= 1'b1;
      else if (done_clear)    done_q <= 1'b0;
      if (wr_fire & idle_q & (awaddr == A_DLEN)) dlen_q <= wdata;
      if (wr_fire & idle_q & (awaddr == A_TLEN)) tlen_q <= wdata;
    end
  end

  assign rvalid       = rvalid_q;
  assign rdata        = rdata_q;
  assign eng_start    = start_q;
  assign eng_idle     = idle_q;
  assign cfg_data_len = dlen_q;
  assign cfg_tap_len  = tlen_q;

  p_rhold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata));
  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start && !eng_idle);
  p_busy_nowrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |-> ram_we == '0);
  p_engine_port_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !eng_idle |-> ram_en == eng_ram_en && ram_addr == eng_ram_addr);
  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> eng_idle);
  p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && rready && rd_addr_q == A_CTRL && rdata[2:1] == 2'b11 |=> !done_q);
  p_collide_r12: assert property (@(posedge clk) disable iff (!rst_n)
    awvalid && wvalid && arvalid |-> !arready);
endmodule

// File: tb/sim_fir_cfg_slave.sv
module sim_fir_cfg_slave;
  logic clk = 1'b0, rst_n = 1'b0;
  logic awvalid = 0, wvalid = 0, arvalid = 0, rready = 0, eng_done = 0, eng_ram_en = 0;
  logic [11:0] awaddr = 0, araddr = 0, eng_ram_addr = 0;
  logic [31:0] wdata = 0;
  logic awready, wready, arready, rvalid, eng_start, eng_idle, ram_en;
  logic [31:0] rdata, cfg_data_len, cfg_tap_len, ram_wdata, ram_rdata;
  logic [3:0] ram_we;
  logic [11:0] ram_addr;
  logic [31:0] mem [32];
  logic [31:0] exp_q [$];
  string tag_q [$];
  logic hs_en;
  logic [3:0] hs_we;
  logic [11:0] hs_addr;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  fir_cfg_slave u0 (.clk, .rst_n, .awvalid, .awready, .awaddr, .wvalid, .wready, .wdata,
    .arvalid, .arready, .araddr, .rvalid, .rready, .rdata, .eng_done, .eng_start, .eng_idle,
    .cfg_data_len, .cfg_tap_len, .eng_ram_en, .eng_ram_addr, .ram_en, .ram_we, .ram_addr,
    .ram_wdata, .ram_rdata);

  initial for (int i = 0; i < 32; i++) mem[i] = 32'h0;
  always @(posedge clk) if (ram_en) begin
    if (ram_we != 0) mem[ram_addr[6:2]] <= ram_wdata;
    ram_rdata <= mem[ram_addr[6:2]];
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial forever begin
    @(negedge clk); #1;
    if (rvalid && rready) begin
      if (exp_q.size() == 0) chk("R3 unexpected read", 1, 0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input int order);
    @(negedge clk);
    if (order == 1) begin
      awvalid = 1; awaddr = a; #1;
      chk("R2 aw alone no ready", {31'b0, awready | wready}, 0);
      @(negedge clk);
    end else if (order == 2) begin
      wvalid = 1; wdata = d; #1;
      chk("R2 w alone no ready", {31'b0, awready | wready}, 0);
      @(negedge clk);
    end
    awvalid = 1; wvalid = 1; awaddr = a; wdata = d; #1;
    chk("R2 ready pair", {30'b0, awready, wready}, 2'b11);
    hs_en = ram_en; hs_we = ram_we; hs_addr = ram_addr;
    @(posedge clk); @(negedge clk);
    awvalid = 0; wvalid = 0;
  endtask

  task automatic rd_finish(input logic [31:0] e, input string tag, input int hold);
    logic [31:0] first;
    chk("R3 rvalid low one cycle after handshake", {31'b0, rvalid}, 0);
    @(negedge clk);
    chk("R3 rvalid high two cycles after handshake", {31'b0, rvalid}, 1);
    first = rdata;
    repeat (hold) @(negedge clk);
    chk("R3 rvalid held", {31'b0, rvalid}, 1);
    chk("R3 rdata stable", rdata, first);
    exp_q.push_back(e); tag_q.push_back(tag);
    rready = 1;
    @(posedge clk); @(negedge clk);
    rready = 0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string tag, input int hold);
    @(negedge clk);
    arvalid = 1; araddr = a; #1;
    while (!arready) begin @(negedge clk); #1; end
    @(posedge clk); @(negedge clk);
    arvalid = 0; araddr = 12'hFFF;
    rd_finish(e, tag, hold);
  endtask

  initial begin
    #(8 * 100000);
    chk("watchdog", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 idle", {31'b0, eng_idle}, 1);
    chk("R1 start", {31'b0, eng_start}, 0);
    chk("R1 data len", cfg_data_len, 0);
    chk("R1 tap len", cfg_tap_len, 0);
    chk("R1 rvalid", {31'b0, rvalid}, 0);
    rd(12'h000, 32'h4, "R1 status word", 0);
    rd(12'h010, 32'h0, "R1 data len read", 1);

    wr(12'h080, 32'd11, 0);
    chk("R4 en", {31'b0, hs_en}, 1); chk("R4 we", {28'b0, hs_we}, 4'hF);
    chk("R4 addr", {20'b0, hs_addr}, 12'h000);
    wr(12'h084, 32'd22, 1);
    wr(12'h0FC, 32'd33, 2);
    chk("R4 masked addr", {20'b0, hs_addr}, 12'h07C);
    rd(12'h084, 32'd22, "R4 coef readback", 0);
    rd(12'h0FC, 32'd33, "R4 coef top readback", 3);

    wr(12'h010, 32'd40, 0);
    wr(12'h014, 32'd3, 1);
    chk("R5 data len out", cfg_data_len, 32'd40);
    chk("R5 tap len out", cfg_tap_len, 32'd3);
    rd(12'h014, 32'd3, "R5 tap len read", 2);

    wr(12'h040, 32'd5, 0);
    chk("R11 unmapped write no ram", {31'b0, hs_en}, 0);
    rd(12'h040, 32'd0, "R11 unmapped read", 0);
    rd(12'h004, 32'd0, "R11 unmapped read 04", 0);

    @(negedge clk);
    awvalid = 1; wvalid = 1; awaddr = 12'h088; wdata = 32'd44;
    arvalid = 1; araddr = 12'h080; #1;
    chk("R12 write wins", {30'b0, awready, arready}, 2'b10);
    @(posedge clk); @(negedge clk);
    awvalid = 0; wvalid = 0; #1;
    chk("R12 read next", {31'b0, arready}, 1);
    @(posedge clk); @(negedge clk);
    arvalid = 0;
    rd_finish(32'd11, "R12 collided read data", 1);
    rd(12'h088, 32'd44, "R12 collided write stored", 0);

    @(negedge clk);
    eng_ram_en = 1; eng_ram_addr = 12'h030; #1;
    chk("R10 idle engine addr", {20'b0, ram_addr}, 12'h030);
    chk("R10 idle engine en", {31'b0, ram_en}, 1);
    chk("R10 idle no we", {28'b0, ram_we}, 0);
    eng_ram_en = 0;

    wr(12'h000, 32'd1, 0);
    chk("R7 start high", {31'b0, eng_start}, 1);
    chk("R7 still idle", {31'b0, eng_idle}, 1);
    @(negedge clk);
    chk("R7 start one cycle", {31'b0, eng_start}, 0);
    chk("R7 idle falls", {31'b0, eng_idle}, 0);

    eng_ram_en = 1; eng_ram_addr = 12'h008;
    wr(12'h080, 32'd99, 0);
    chk("R6 busy coef no we", {28'b0, hs_we}, 0);
    chk("R10 busy engine addr", {20'b0, hs_addr}, 12'h008);
    chk("R10 busy engine en", {31'b0, hs_en}, 1);
    wr(12'h010, 32'd7, 0);
    chk("R6 busy len dropped", cfg_data_len, 32'd40);
    rd(12'h080, 32'hFFFF_FFFF, "R6 busy window read", 1);
    rd(12'h000, 32'h0, "R7 busy status", 0);
    wr(12'h000, 32'd1, 0);
    chk("R7 start ignored while busy", {31'b0, eng_start}, 0);
    eng_ram_en = 0;

    @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    chk("R8 idle after done", {31'b0, eng_idle}, 1);
    rd(12'h000, 32'h6, "R8 status idle+done", 2);
    rd(12'h000, 32'h4, "R9 done cleared", 0);
    rd(12'h080, 32'd11, "R6 busy write dropped", 0);
    rd(12'h010, 32'd40, "R6 busy len kept", 0);

    wr(12'h000, 32'd1, 0);
    chk("R7 restart", {31'b0, eng_start}, 1);
    @(negedge clk); @(negedge clk); eng_done = 1;
    @(negedge clk); eng_done = 0;
    rd(12'h000, 32'h6, "R8 second done", 0);

    repeat (4) @(negedge clk);
    chk("R3 scoreboard drained", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule